// File: doc/BRIEF.md
# Disk DMA Chunk Sequencer

This block sits between a descriptor-driven DMA channel and a drive engine that serves either a hard disk or an optical drive. It steers one multi-chunk block transfer. A start pulse loads the number of bytes still owed and clears a running byte index. The DMA channel then presents chunks as (memory address, length) pairs. For each chunk the block works out the byte offset on the media, places one request on the block port, and after the port accepts it moves its counters forward.

A transfer closes when a chunk arrives while the owed byte count is zero or below. A disk then reports ready-and-seek status with a drive interrupt, and an optical drive reports command success. A chunk that arrives before a transfer has been armed moves no data; it is handed back as stalled, so that the channel can wait for a restart. An optical transfer whose block address is all ones is a packet reply and not a block transfer. It is served as one local copy, after which the command completes at once. A failing completion ends the transfer with an error.

Top module: `dma_chunk_seq`

## Requirements
- R1: A `start` pulse while idle loads the owed count (`sector_count`*512 for a disk, `packet_size` when `is_optical`=1), clears the index, sets `xfer_active` and sets `status` to 8'h80 one cycle later. Reset clears every output and `status`.
- R2: A chunk presented while `xfer_active`=0 is answered with `chunk_ack` and `chunk_stall` both high for one cycle, and no block request is made.
- R3: A chunk presented while active with an owed count of zero or less ends the transfer with no block request. A disk pulses `drive_irq`, an optical drive pulses `cmd_ok`, `status` becomes 8'h50 and `xfer_active` clears.
- R4: A zero-length chunk on an active transfer with bytes still owed is acknowledged without a block request and leaves the counters and `xfer_active` unchanged.
- R5: The block offset is `media_lba`*512 + index for a disk and `media_lba`*2048 + index for an optical drive.
- R6: When the block port accepts a request, the owed count drops by the chunk length and the index rises by the same amount. `blk_len` carries the chunk length.
- R7: An optical transfer with `media_lba` = 32'hFFFFFFFF issues `blk_op`=3 (local copy) at offset 0 with length min(owed, chunk length). A good completion of that request pulses `cmd_ok`, sets `status` to 8'h50 and clears `xfer_active`.
- R8: A completion with `blk_err`=1 pulses `xfer_err`, sets `status` to 8'h41 and clears `xfer_active`.
- R9: For a disk, `disk_cmd` 0/1/2 selects `blk_op` 0 (read), 1 (write) or 2 (trim). `blk_to_dev` is 1 for write and trim. Optical block requests use `blk_op`=0. `disk_cmd`=3 on a disk is illegal: it ends the transfer as in R8 without a block request.
- R10: `blk_req` and its fields stay stable until `blk_ready` is sampled high. `chunk_ack` is a one-cycle pulse, issued in the cycle after acceptance.
- R11: Only one block request is outstanding. No chunk is acknowledged between acceptance and `blk_done`, and a `blk_done` that arrives while nothing is outstanding has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arms a new transfer (taken while idle) |
| is_optical | input | 1 | 1: optical drive, 0: hard disk |
| sector_count | input | SEC_W | Disk sectors to move |
| packet_size | input | CNT_W | Optical bytes to move |
| media_lba | input | LBA_W | Starting sector / block address |
| disk_cmd | input | 2 | 0 read, 1 write, 2 trim, 3 illegal |
| chunk_req | input | 1 | DMA channel presents a chunk |
| chunk_addr | input | ADDR_W | Chunk memory address |
| chunk_len | input | CNT_W | Chunk length in bytes |
| chunk_ack | output | 1 | Chunk handled (pulse) |
| chunk_stall | output | 1 | Chunk refused, transfer not armed (pulse) |
| blk_req | output | 1 | Block request valid |
| blk_ready | input | 1 | Block port accepts the request |
| blk_off | output | OFF_W | Media byte offset |
| blk_len | output | CNT_W | Request length in bytes |
| blk_addr | output | ADDR_W | Memory address of the request |
| blk_op | output | 2 | 0 read, 1 write, 2 trim, 3 local copy |
| blk_to_dev | output | 1 | Data flows toward the device |
| blk_done | input | 1 | Request completed (pulse) |
| blk_err | input | 1 | Completion failed (with blk_done) |
| xfer_active | output | 1 | Transfer armed |
| status | output | 8 | Drive status byte |
| drive_irq | output | 1 | Disk transfer finished (pulse) |
| cmd_ok | output | 1 | Optical command finished (pulse) |
| xfer_err | output | 1 | Transfer failed (pulse) |

## Verification
Disk transfers run once with each command code. This shows that the code selects the operation and the direction, and that illegal codes are rejected. Optical transfers with block-sized chunks show that the offset is scaled by 2048 and not by 512. The all-ones address shows that a packet copy is clipped to the shorter of the two lengths, whichever of them is the smaller. Chunks that overshoot the owed count show that a negative count still closes the transfer. Varying the port stall length, holding a chunk request while a request is outstanding, and sending stray completions show that the handshake holds its fields, never overlaps requests and ignores completions that match no request.

// File: rtl/dma_chunk_seq.sv
module dma_chunk_seq #(
  parameter int CNT_W  = 32,
  parameter int SEC_W  = 16,
  parameter int LBA_W  = 32,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_optical,
  input  logic [SEC_W-1:0]  sector_count,
  input  logic [CNT_W-1:0]  packet_size,
  input  logic [LBA_W-1:0]  media_lba,
  input  logic [1:0]        disk_cmd,
  input  logic              chunk_req,
  input  logic [ADDR_W-1:0] chunk_addr,
  input  logic [CNT_W-1:0]  chunk_len,
  output logic              chunk_ack,
  output logic              chunk_stall,
  output logic              blk_req,
  input  logic              blk_ready,
  output logic [OFF_W-1:0]  blk_off,
  output logic [CNT_W-1:0]  blk_len,
  output logic [ADDR_W-1:0] blk_addr,
  output logic [1:0]        blk_op,
  output logic              blk_to_dev,
  input  logic              blk_done,
  input  logic              blk_err,
  output logic              xfer_active,
  output logic [7:0]        status,
  output logic              drive_irq,
  output logic              cmd_ok,
  output logic              xfer_err
);
  localparam logic [7:0] ST_BUSY = 8'h80;
  localparam logic [7:0] ST_DONE = 8'h50;
  localparam logic [7:0] ST_FAIL = 8'h41;
  localparam logic [1:0] OP_COPY = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_t;
  state_t state;

  logic signed [CNT_W-1:0] owed;
  logic [CNT_W-1:0] idx;
  logic [LBA_W-1:0] lba_q;
  logic [1:0]       cmd_q;
  logic             opt_q, copy_q;

  wire packet_copy = opt_q && (lba_q == {LBA_W{1'b1}});
  wire illegal     = !opt_q && (cmd_q == 2'd3);
  wire [OFF_W-1:0] base = opt_q ? (OFF_W'(lba_q) << 11) : (OFF_W'(lba_q) << 9);
  wire [CNT_W-1:0] clip = ($unsigned(owed) < chunk_len) ? $unsigned(owed) : chunk_len;
  wire take = chunk_req && !chunk_ack;

  assign blk_to_dev = (blk_op == 2'd1) || (blk_op == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      owed <= '0; idx <= '0; lba_q <= '0; cmd_q <= '0; opt_q <= 1'b0; copy_q <= 1'b0;
      chunk_ack <= 1'b0; chunk_stall <= 1'b0;
      blk_req <= 1'b0; blk_off <= '0; blk_len <= '0; blk_addr <= '0; blk_op <= '0;
      xfer_active <= 1'b0; status <= '0;
      drive_irq <= 1'b0; cmd_ok <= 1'b0; xfer_err <= 1'b0;
    end else begin
      chunk_ack <= 1'b0; chunk_stall <= 1'b0;
      drive_irq <= 1'b0; cmd_ok <= 1'b0; xfer_err <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            opt_q <= is_optical;
            lba_q <= media_lba;
            cmd_q <= disk_cmd;
            idx   <= '0;
            owed  <= is_optical ? packet_size : CNT_W'({sector_count, 9'd0});
            xfer_active <= 1'b1;
            status <= ST_BUSY;
          end else if (take) begin
            if (!xfer_active) begin
              chunk_ack <= 1'b1; chunk_stall <= 1'b1;
            end else if (owed <= 0) begin
              chunk_ack <= 1'b1;
              xfer_active <= 1'b0;
              status <= ST_DONE;
              if (opt_q) cmd_ok <= 1'b1;
              else drive_irq <= 1'b1;
            end else if (chunk_len == '0) begin
              chunk_ack <= 1'b1;
            end else if (illegal) begin
              chunk_ack <= 1'b1;
              xfer_err <= 1'b1;
              status <= ST_FAIL;
              xfer_active <= 1'b0;
            end else begin
              blk_req  <= 1'b1;
              blk_addr <= chunk_addr;
              copy_q   <= packet_copy;
              blk_off  <= packet_copy ? '0 : base + OFF_W'(idx);
              blk_len  <= packet_copy ? clip : chunk_len;
              blk_op   <= packet_copy ? OP_COPY : (opt_q ? 2'd0 : cmd_q);
              state    <= S_REQ;
            end
          end
        end
        S_REQ: if (blk_ready) begin
          blk_req <= 1'b0;
          chunk_ack <= 1'b1;
          if (!copy_q) begin
            owed <= owed - $signed(blk_len);
            idx  <= idx + blk_len;
          end
          state <= S_WAIT;
        end
        default: if (blk_done) begin
          state <= S_IDLE;
          if (blk_err) begin
            xfer_err <= 1'b1;
            status <= ST_FAIL;
            xfer_active <= 1'b0;
          end else if (copy_q) begin
            cmd_ok <= 1'b1;
            status <= ST_DONE;
            xfer_active <= 1'b0;
          end
        end
      endcase
    end
  end

  p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_ack |=> !chunk_ack);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_req && !blk_ready) |=> (blk_req && $stable(blk_off) && $stable(blk_len) && $stable(blk_op)));
  p_stall_noreq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_stall |-> (!blk_req && !xfer_active));
  p_end_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_irq || cmd_ok) |-> (!xfer_active && status == ST_DONE));
  p_err_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |-> (!xfer_active && status == ST_FAIL));
  p_single_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_req && blk_ready) |=> (!blk_req && !chunk_stall));
endmodule

// File: tb/test_dma_chunk_seq.sv
module test_dma_chunk_seq;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic start = 0, is_optical = 0;
  logic [15:0] sector_count = 0;
  logic [31:0] packet_size = 0, media_lba = 0, chunk_addr = 0, chunk_len = 0;
  logic [1:0] disk_cmd = 0;
  logic chunk_req = 0, blk_ready = 0, blk_done = 0, blk_err = 0;
  logic chunk_ack, chunk_stall, blk_req, blk_to_dev, xfer_active, drive_irq, cmd_ok, xfer_err;
  logic [63:0] blk_off;
  logic [31:0] blk_len, blk_addr;
  logic [1:0] blk_op;
  logic [7:0] status;

  dma_chunk_seq i_dma_chunk_seq (.*);

  int checks = 0, errors = 0;
  bit run = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_st;
  bit m_active, m_opt, m_pass;
  longint m_rem, m_idx, m_lba;
  int m_cmd;
  bit e_ack, e_stall, e_req, e_irq, e_ok, e_err;
  longint e_off, e_len, e_addr;
  int e_op, e_status;

  always @(posedge clk) begin
    bit pa;
    if (!rst_n) begin
      m_st = 0; m_active = 0; m_opt = 0; m_pass = 0; m_rem = 0; m_idx = 0; m_lba = 0; m_cmd = 0;
      e_ack = 0; e_stall = 0; e_req = 0; e_irq = 0; e_ok = 0; e_err = 0;
      e_off = 0; e_len = 0; e_addr = 0; e_op = 0; e_status = 0;
    end else begin
      pa = e_ack;
      e_ack = 0; e_stall = 0; e_irq = 0; e_ok = 0; e_err = 0;
      if (m_st == 0) begin
        if (start) begin
          m_opt = is_optical; m_lba = media_lba; m_cmd = disk_cmd; m_idx = 0;
          m_rem = is_optical ? longint'(packet_size) : longint'(sector_count) * 512;
          m_active = 1; e_status = 8'h80;
        end else if (chunk_req && !pa) begin
          if (!m_active) begin e_ack = 1; e_stall = 1; end
          else if (m_rem <= 0) begin
            e_ack = 1; m_active = 0; e_status = 8'h50;
            if (m_opt) e_ok = 1; else e_irq = 1;
          end else if (chunk_len == 0) e_ack = 1;
          else if (!m_opt && m_cmd == 3) begin
            e_ack = 1; e_err = 1; e_status = 8'h41; m_active = 0;
          end else begin
            e_req = 1; e_addr = chunk_addr; m_st = 1;
            if (m_opt && m_lba == 64'hFFFF_FFFF) begin
              m_pass = 1; e_off = 0; e_op = 3;
              e_len = (m_rem < longint'(chunk_len)) ? m_rem : longint'(chunk_len);
            end else begin
              m_pass = 0; e_len = chunk_len;
              e_off = (m_opt ? m_lba * 2048 : m_lba * 512) + m_idx;
              e_op = m_opt ? 0 : m_cmd;
            end
          end
        end
      end else if (m_st == 1) begin
        if (blk_ready) begin
          e_req = 0; e_ack = 1; m_st = 2;
          if (!m_pass) begin m_rem -= e_len; m_idx += e_len; end
        end
      end else if (blk_done) begin
        m_st = 0;
        if (blk_err) begin e_err = 1; e_status = 8'h41; m_active = 0; end
        else if (m_pass) begin e_ok = 1; e_status = 8'h50; m_active = 0; end
      end
    end
  end

  always @(negedge clk) if (run) begin
    chk("R10 chunk_ack", chunk_ack, e_ack);
    chk("R2 chunk_stall", chunk_stall, e_stall);
    chk("R11 blk_req", blk_req, e_req);
    chk("R5 blk_off", blk_off, e_off);
    chk("R6 blk_len", blk_len, e_len);
    chk("R10 blk_addr", blk_addr, e_addr);
    chk("R9 blk_op", blk_op, e_op);
    chk("R9 blk_to_dev", blk_to_dev, (e_op == 1 || e_op == 2));
    chk("R3 drive_irq", drive_irq, e_irq);
    chk("R7 cmd_ok", cmd_ok, e_ok);
    chk("R8 xfer_err", xfer_err, e_err);
    chk("R1 status", status, e_status);
    chk("R1 xfer_active", xfer_active, m_active);
  end

  task automatic arm(input bit opt, input int ns, input int pkt, input logic [31:0] lba, input int cmd);
    @(negedge clk);
    is_optical = opt; sector_count = 16'(ns); packet_size = pkt; media_lba = lba; disk_cmd = 2'(cmd);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic send_chunk(input logic [31:0] a, input logic [31:0] l, input int rdly, input bit err);
    int n = 0;
    bit issued = 0;
    @(negedge clk);
    chunk_req = 1; chunk_addr = a; chunk_len = l;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (chunk_ack) break;
      if (blk_req) begin issued = 1; n++; blk_ready = (n > rdly); end
    end
    chunk_req = 0; blk_ready = 0;
    if (issued) begin
      chunk_req = 1;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk("R11 no ack while outstanding", chunk_ack, 0);
      end
      chunk_req = 0; blk_done = 1; blk_err = err;
      @(negedge clk);
      blk_done = 0; blk_err = 0;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset status", status, 0);
    chk("R1 reset active", xfer_active, 0);
    run = 1;
    send_chunk(32'h1000, 512, 0, 0);          // R2 not armed
    arm(0, 2, 0, 100, 0);                     // disk read, 1024 bytes
    send_chunk(32'h2000, 512, 0, 0);          // R5 offset 51200
    send_chunk(32'h2200, 0, 0, 0);            // R4 zero length
    chk("R4 stays active", xfer_active, 1);
    chk("R4 no request", blk_req, 0);
    send_chunk(32'h2200, 512, 3, 0);          // R10 stalled port
    send_chunk(32'h2400, 512, 0, 0);          // R3 finish disk
    chk("R3 irq path status", status, 8'h50);
    arm(0, 1, 0, 7, 1);                       // R9 write
    send_chunk(32'h3000, 256, 1, 0);
    send_chunk(32'h3100, 256, 0, 0);
    send_chunk(32'h3200, 64, 0, 0);
    arm(0, 1, 0, 9, 2);                       // R9 trim
    send_chunk(32'h4000, 512, 2, 0);
    send_chunk(32'h4200, 512, 0, 0);
    arm(0, 1, 0, 9, 3);                       // R9 illegal
    send_chunk(32'h5000, 512, 0, 0);
    chk("R9 illegal ends", status, 8'h41);
    arm(0, 4, 0, 20, 0);                      // R8 error completion
    send_chunk(32'h6000, 512, 0, 1);
    chk("R8 error status", status, 8'h41);
    send_chunk(32'h6200, 512, 0, 0);          // R2 after error
    arm(1, 0, 4096, 3, 1);                    // R5 optical
    send_chunk(32'h7000, 2048, 0, 0);
    send_chunk(32'h7800, 2048, 1, 0);
    send_chunk(32'h8000, 2048, 0, 0);
    arm(1, 0, 100, 32'hFFFF_FFFF, 0);         // R7 packet copy clipped
    send_chunk(32'h9000, 300, 0, 0);
    chk("R7 copy done", status, 8'h50);
    arm(1, 0, 100, 32'hFFFF_FFFF, 0);         // R7 chunk shorter
    send_chunk(32'h9400, 40, 0, 0);
    arm(0, 1, 0, 5, 0);                       // R6 overshoot to negative
    send_chunk(32'hA000, 1000, 0, 0);
    send_chunk(32'hA400, 16, 0, 0);
    chk("R3 negative closes", xfer_active, 0);
    @(negedge clk); blk_done = 1; blk_err = 1;  // R11 stray completion
    @(negedge clk); blk_done = 0; blk_err = 0;
    @(negedge clk);
    chk("R11 stray done ignored", xfer_err, 0);
    chk("R11 stray status", status, 8'h50);
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule